// File: doc/BRIEF.md
# Chroma-Key Layer Compositor

This block is one pixel-stream stage of a display pipeline. It takes an upper graphics pixel and the lower-layer pixel that sits beneath it, both in RGB565 form, and produces the composited pixel. Every upper pixel is compared with a programmable key colour. When keying is enabled and all three colour components match, the upper pixel is swapped for a programmable replacement colour. That colour is then alpha-blended onto the lower pixel with an 8-bit alpha. Any other pixel passes through unchanged and covers the lower layer completely.

Settings arrive through a small register write port and land in shadow copies. At each vsync pulse the shadow copies are moved into the active copies, but only while the update flag is set. Pixels therefore never see a half-written configuration in the middle of a frame. An instance built as the bottom layer has nothing beneath it, so it disregards all key settings and outputs the upper pixel as it is.

The datapath is a fixed two-stage pipeline with a valid qualifier on each side. It has no back-pressure: there is no ready signal, and each accepted pixel appears on the output exactly two clocks later, whatever happens downstream. Reset is synchronous and active high.

Top module: `chroma_key_compositor`

## Requirements
- R1: Register address 0 is the key control word. Bit 16 is the keying enable, bits 15:11 the red key, bits 10:5 the green key and bits 4:0 the blue key. Reading it returns bits 31:17 as zero.
- R2: Address 1 holds the replacement colour (RGB565, bits 15:0), address 2 the alpha (bits 7:0) and address 3 the update flag (bit 0). Reads return the shadow copies. Writes to these registers have no effect on pixels until a vsync pulse arrives with the update flag at 1.
- R3: A vsync pulse while the shadow update flag is 0 leaves the active settings unchanged.
- R4: A pixel whose components match the key only partly is treated as a non-match.
- R5: When keying is enabled and red, green and blue all equal their key fields, the output is the blend of the replacement colour over the lower pixel. Each component is widened to 8 bits by repeating its top bits, combined as (a*fg + (255-a)*bg + 127)/255 and truncated back to RGB565.
- R6: When the active enable bit is 0, no comparison or replacement happens and the upper pixel passes unchanged.
- R7: A non-matching upper pixel appears unchanged at the output, fully opaque.
- R8: out_valid is asserted exactly two clocks after in_valid, and the output pixel belongs to that input. There is no back-pressure.
- R9: An instance built with BOTTOM_LAYER=1 ignores the key settings and outputs the upper pixel unchanged.
- R10: Reset clears every register and the active settings, and deasserts out_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Shadow register read data at cfg_addr |
| vsync | input | 1 | Frame sync pulse, one clock wide |
| in_valid | input | 1 | Input pixel pair valid |
| in_upper | input | 16 | Upper-layer pixel, RGB565 |
| in_lower | input | 16 | Lower-layer pixel, RGB565 |
| out_valid | output | 1 | Output pixel valid |
| out_pixel | output | 16 | Composited pixel, RGB565 |

## Verification
The bench builds two instances that share one stimulus stream. One uses the default BOTTOM_LAYER=0, which reaches key matching, partial matches, replacement blending at alpha 0, 128 and 255, and the vsync and flag rules. The other uses BOTTOM_LAYER=1, which shows that identical key settings leave a bottom layer untouched. Vsync pulses are placed in the middle of a pixel run and on the same cycle as a register write, so the edge at which settings change is pinned down.

// File: rtl/ckc_pkg.sv
package ckc_pkg;
  localparam int R_W   = 5;
  localparam int G_W   = 6;
  localparam int B_W   = 5;
  localparam int PIX_W = R_W + G_W + B_W;
  localparam int CH_W  = 8;
  localparam int A_W   = 8;

  typedef logic [PIX_W-1:0] pix_t;

  typedef struct packed {
    logic en;
    pix_t key;
  } keyctl_t;

  typedef struct packed {
    keyctl_t          ctl;
    pix_t             repl;
    logic [A_W-1:0]   alpha;
  } cfg_t;

  // Widen RGB565 to three 8-bit channels by repeating the top bits.
  function automatic logic [3*CH_W-1:0] widen(pix_t p);
    logic [R_W-1:0] r;
    logic [G_W-1:0] g;
    logic [B_W-1:0] b;
    r = p[PIX_W-1 -: R_W];
    g = p[B_W +: G_W];
    b = p[B_W-1:0];
    return {r, r[R_W-1 -: CH_W-R_W], g, g[G_W-1 -: CH_W-G_W], b, b[B_W-1 -: CH_W-B_W]};
  endfunction

  // Truncate three 8-bit channels back to RGB565.
  function automatic pix_t narrow(logic [3*CH_W-1:0] c);
    return {c[3*CH_W-1 -: R_W], c[2*CH_W-1 -: G_W], c[CH_W-1 -: B_W]};
  endfunction
endpackage

// File: rtl/ckc_regs.sv
module ckc_regs
  import ckc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        wr,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        vsync,
  output logic        upd_flag,
  output cfg_t        act
);
  cfg_t sh;
  logic unused_wbits;
  assign unused_wbits = ^wdata[31:PIX_W+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      act      <= '0;
      upd_flag <= 1'b0;
    end else begin
      if (wr) begin
        case (addr)
          2'd0: sh.ctl   <= wdata[PIX_W:0];
          2'd1: sh.repl  <= wdata[PIX_W-1:0];
          2'd2: sh.alpha <= wdata[A_W-1:0];
          default: upd_flag <= wdata[0];
        endcase
      end
      if (vsync && upd_flag) act <= sh;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {{(32-PIX_W-1){1'b0}}, sh.ctl};
      2'd1:    rdata = {{(32-PIX_W){1'b0}}, sh.repl};
      2'd2:    rdata = {{(32-A_W){1'b0}}, sh.alpha};
      default: rdata = {31'd0, upd_flag};
    endcase
  end
endmodule

// File: rtl/ckc_match.sv
module ckc_match
  import ckc_pkg::*;
(
  input  pix_t    pix,
  input  keyctl_t ctl,
  output logic    hit
);
  logic r_eq, g_eq, b_eq;
  assign r_eq = pix[PIX_W-1 -: R_W] == ctl.key[PIX_W-1 -: R_W];
  assign g_eq = pix[B_W +: G_W]     == ctl.key[B_W +: G_W];
  assign b_eq = pix[B_W-1:0]        == ctl.key[B_W-1:0];
  assign hit  = ctl.en && r_eq && g_eq && b_eq;
endmodule

// File: rtl/ckc_blend_lane.sv
module ckc_blend_lane #(
  parameter int CH_W = 8,
  parameter int A_W  = 8
) (
  input  logic [A_W-1:0]  alpha,
  input  logic [CH_W-1:0] fg,
  input  logic [CH_W-1:0] bg,
  output logic [CH_W-1:0] mix
);
  localparam int SUM_W = CH_W + A_W + 1;
  localparam logic [SUM_W-1:0] FULL = SUM_W'((1 << A_W) - 1);
  localparam logic [SUM_W-1:0] HALF = SUM_W'(((1 << A_W) - 1) / 2);

  logic [SUM_W-1:0] sum, quo;
  assign sum = SUM_W'(alpha) * SUM_W'(fg) + (FULL - SUM_W'(alpha)) * SUM_W'(bg) + HALF;
  assign quo = sum / FULL;
  assign mix = quo[CH_W-1:0];
endmodule

// File: rtl/chroma_key_compositor.sv
module chroma_key_compositor
  import ckc_pkg::*;
#(
  parameter bit BOTTOM_LAYER = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        vsync,
  input  logic        in_valid,
  input  logic [15:0] in_upper,
  input  logic [15:0] in_lower,
  output logic        out_valid,
  output logic [15:0] out_pixel
);
  localparam logic [A_W-1:0] OPAQUE = '1;

  cfg_t act_cfg;
  logic upd_flag;
  logic hit;

  ckc_regs u_regs (
    .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .vsync(vsync), .upd_flag(upd_flag), .act(act_cfg)
  );

  generate
    if (BOTTOM_LAYER) begin : g_bottom
      assign hit = 1'b0;
    end else begin : g_keyed
      ckc_match u_match (.pix(in_upper), .ctl(act_cfg.ctl), .hit(hit));
    end
  endgenerate

  // Stage 1: key decision and colour selection
  logic           s1_valid;
  pix_t           s1_fg, s1_bg;
  logic [A_W-1:0] s1_alpha;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_fg    <= '0;
      s1_bg    <= '0;
      s1_alpha <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_fg    <= hit ? act_cfg.repl  : in_upper;
      s1_alpha <= hit ? act_cfg.alpha : OPAQUE;
      s1_bg    <= in_lower;
    end
  end

  // Stage 2: per-channel blend
  logic [3*CH_W-1:0] fg_w, bg_w, mix_w;
  assign fg_w = widen(s1_fg);
  assign bg_w = widen(s1_bg);

  generate
    for (genvar i = 0; i < 3; i++) begin : g_lane
      ckc_blend_lane #(.CH_W(CH_W), .A_W(A_W)) u_lane (
        .alpha(s1_alpha),
        .fg(fg_w[i*CH_W +: CH_W]),
        .bg(bg_w[i*CH_W +: CH_W]),
        .mix(mix_w[i*CH_W +: CH_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= s1_valid;
      out_pixel <= narrow(mix_w);
    end
  end
endmodule

// File: rtl/ckc_checker.sv
module ckc_checker
  import ckc_pkg::*;
#(
  parameter bit BOTTOM_LAYER = 1'b0
) (
  input logic        clk,
  input logic        rst,
  input logic        vsync,
  input logic        upd_flag,
  input cfg_t        act_cfg,
  input logic [1:0]  cfg_addr,
  input logic [31:0] cfg_rdata,
  input logic        in_valid,
  input logic [15:0] in_upper,
  input logic        out_valid,
  input logic [15:0] out_pixel
);
  a_r1_rsv_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == 2'd0) |-> (cfg_rdata[31:17] == 15'd0));

  a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !vsync |=> $stable(act_cfg));

  a_r3_no_flag_no_load: assert property (@(posedge clk) disable iff (rst)
    (vsync && !upd_flag) |=> $stable(act_cfg));

  a_r8_latency_fwd: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  generate
    if (BOTTOM_LAYER) begin : g_bot
      a_r9_bottom_pass: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(in_valid, 2)) |-> (out_pixel == $past(in_upper, 2)));
    end else begin : g_top
      logic unused_pix;
      assign unused_pix = ^{in_upper, out_pixel};
    end
  endgenerate
endmodule

bind chroma_key_compositor ckc_checker #(.BOTTOM_LAYER(BOTTOM_LAYER)) u_chk (
  .clk(clk), .rst(rst), .vsync(vsync), .upd_flag(upd_flag), .act_cfg(act_cfg),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
  .in_upper(in_upper), .out_valid(out_valid), .out_pixel(out_pixel)
);

// File: tb/chroma_key_compositor_tb.sv
module chroma_key_compositor_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        vsync;
  logic        in_valid;
  logic [15:0] in_upper, in_lower;
  logic [31:0] rd_a, rd_b;
  logic        ov_a, ov_b;
  logic [15:0] op_a, op_b;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chroma_key_compositor #(.BOTTOM_LAYER(1'b0)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_a), .vsync(vsync), .in_valid(in_valid), .in_upper(in_upper),
    .in_lower(in_lower), .out_valid(ov_a), .out_pixel(op_a));

  chroma_key_compositor #(.BOTTOM_LAYER(1'b1)) u_bot (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_b), .vsync(vsync), .in_valid(in_valid), .in_upper(in_upper),
    .in_lower(in_lower), .out_valid(ov_b), .out_pixel(op_b));

  // Behavioural reference model
  int sh_en, sh_key, sh_repl, sh_alpha, sh_flag;
  int ac_en, ac_key, ac_repl, ac_alpha;
  int p1[$], p2[$];        // expected pixel pipeline, keyed instance
  string t1[$];            // tag pipeline
  int b1[$];               // expected pixel pipeline, bottom instance
  int v1[$];               // valid pipeline

  function automatic int w5(int c); return c * 8 + c / 4; endfunction
  function automatic int w6(int c); return c * 4 + c / 16; endfunction
  function automatic int mixc(int a, int f, int b); return (a * f + (255 - a) * b + 127) / 255; endfunction

  function automatic int blend(int a, int f, int b);
    int r, g, bl;
    r  = mixc(a, w5((f >> 11) & 31), w5((b >> 11) & 31)) / 8;
    g  = mixc(a, w6((f >> 5) & 63),  w6((b >> 5) & 63))  / 4;
    bl = mixc(a, w5(f & 31),         w5(b & 31))          / 8;
    return (r << 11) | (g << 5) | bl;
  endfunction

  always @(posedge clk) begin
    int exp_p, ex_b;
    string tag;
    if (rst) begin
      sh_en = 0; sh_key = 0; sh_repl = 0; sh_alpha = 0; sh_flag = 0;
      ac_en = 0; ac_key = 0; ac_repl = 0; ac_alpha = 0;
      p1 = '{0, 0}; t1 = '{"R10", "R10"}; b1 = '{0, 0}; v1 = '{0, 0};
    end else begin
      int u, l;
      u = int'(in_upper); l = int'(in_lower);
      if (ac_en == 0) begin exp_p = u; tag = "R6"; end
      else if (u == ac_key) begin exp_p = blend(ac_alpha, ac_repl, l); tag = "R5"; end
      else if (((u ^ ac_key) & 16'hF800) == 0 || ((u ^ ac_key) & 16'h07E0) == 0 ||
               ((u ^ ac_key) & 16'h001F) == 0) begin exp_p = u; tag = "R4"; end
      else begin exp_p = u; tag = "R7"; end
      ex_b = u;
      p1.push_back(exp_p); t1.push_back(tag); b1.push_back(ex_b); v1.push_back(int'(in_valid));
      void'(p1.pop_front()); void'(t1.pop_front()); void'(b1.pop_front()); void'(v1.pop_front());
      if (vsync && sh_flag != 0) begin
        ac_en = sh_en; ac_key = sh_key; ac_repl = sh_repl; ac_alpha = sh_alpha;
      end
      if (cfg_wr) begin
        case (cfg_addr)
          2'd0: begin sh_en = int'(cfg_wdata[16]); sh_key = int'(cfg_wdata[15:0]); end
          2'd1: sh_repl = int'(cfg_wdata[15:0]);
          2'd2: sh_alpha = int'(cfg_wdata[7:0]);
          default: sh_flag = int'(cfg_wdata[0]);
        endcase
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!rst && p1.size() == 2) begin
      checks++;
      if (int'(ov_a) != v1[0] || int'(ov_b) != v1[0]) begin
        errors++;
        $display("FAIL R8 valid: actual %0d/%0d expected %0d", ov_a, ov_b, v1[0]);
      end
      if (v1[0] != 0) begin
        checks++;
        if (int'(op_a) != p1[0]) begin
          errors++;
          $display("FAIL %s pixel: actual %04h expected %04h", t1[0], op_a, p1[0][15:0]);
        end
        checks++;
        if (int'(op_b) != b1[0]) begin
          errors++;
          $display("FAIL R9 bottom pixel: actual %04h expected %04h", op_b, b1[0][15:0]);
        end
      end
    end
  end

  task automatic check_rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #1;
    checks++;
    if (rd_a !== exp) begin
      errors++;
      $display("FAIL %s read addr %0d: actual %08h expected %08h", tag, a, rd_a, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit vs = 0);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d; vsync = vs;
    @(negedge clk);
    cfg_wr = 0; vsync = 0;
  endtask

  task automatic pulse_vsync();
    @(negedge clk); vsync = 1;
    @(negedge clk); vsync = 0;
  endtask

  task automatic px(input logic [15:0] u, input logic [15:0] l);
    @(negedge clk);
    in_valid = 1; in_upper = u; in_lower = l;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run(input logic [15:0] key, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = ($urandom % 4) != 0;
      in_upper = (($urandom % 3) == 0) ? key : 16'($urandom);
      in_lower = 16'($urandom);
    end
    @(negedge clk); in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_wr = 0; cfg_addr = 0; cfg_wdata = 0; vsync = 0;
    in_valid = 0; in_upper = 0; in_lower = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (ov_a !== 1'b0) begin errors++; $display("FAIL R10 out_valid: actual %0b expected 0", ov_a); end
    check_rd(2'd0, 32'h0, "R10");
    rst = 0;
    // R1: reserved bits read zero
    wr(2'd0, 32'hFFFF_FFFF);
    check_rd(2'd0, 32'h0001_FFFF, "R1");
    // R2: stage settings; not active yet
    wr(2'd0, 32'h0001_F800);
    wr(2'd1, 32'h0000_001F);
    wr(2'd2, 32'h0000_0180);
    check_rd(2'd2, 32'h0000_0080, "R2");
    px(16'hF800, 16'h07E0);           // enable inactive -> passes (R6)
    // R3: vsync without flag keeps active settings
    pulse_vsync();
    px(16'hF800, 16'h07E0);
    // Arm flag and load
    wr(2'd3, 32'h1);
    check_rd(2'd3, 32'h1, "R2");
    pulse_vsync();
    px(16'hF800, 16'h07E0);           // R5 match, alpha 128
    px(16'hF801, 16'h07E0);           // R4 partial
    px(16'hF820, 16'h1234);           // R4 partial
    px(16'h0800, 16'h1234);           // R4 partial
    px(16'h1234, 16'hABCD);           // R7 non-match
    // alpha extremes
    wr(2'd2, 32'h0, 1'b1);            // write and vsync same edge: old alpha loads
    px(16'hF800, 16'hFFFF);
    pulse_vsync();
    px(16'hF800, 16'hABCD);           // alpha 0 -> lower pixel
    wr(2'd2, 32'hFF);
    pulse_vsync();
    px(16'hF800, 16'hABCD);           // alpha 255 -> replacement
    // R2: shadow change, flag cleared, vsync: no effect
    wr(2'd3, 32'h0);
    wr(2'd1, 32'h0000_FFFF);
    pulse_vsync();
    px(16'hF800, 16'h0000);
    // disable keying (R6)
    wr(2'd0, 32'h0000_F800);
    wr(2'd3, 32'h1);
    pulse_vsync();
    px(16'hF800, 16'h0000);
    // Random stream with mid-stream vsync, key 0x07E0
    wr(2'd0, 32'h0001_07E0);
    wr(2'd2, 32'h5A);
    fork
      run(16'h07E0, 400);
      begin repeat (150) @(negedge clk); vsync = 1; @(negedge clk); vsync = 0; end
    join
    wr(2'd2, 32'hC3);
    fork
      run(16'h07E0, 400);
      begin repeat (90) @(negedge clk); vsync = 1; @(negedge clk); vsync = 0; end
    join
    // R10: reset in mid-stream
    @(negedge clk); in_valid = 1; in_upper = 16'h07E0;
    @(negedge clk); rst = 1; in_valid = 0;
    @(negedge clk);
    checks++;
    if (ov_a !== 1'b0 || ov_b !== 1'b0) begin
      errors++; $display("FAIL R10 out_valid after reset: actual %0b expected 0", ov_a);
    end
    @(negedge clk);
    checks++;
    if (ov_a !== 1'b0) begin errors++; $display("FAIL R10 pipeline flush: actual %0b expected 0", ov_a); end
    check_rd(2'd0, 32'h0, "R10");
    rst = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule